// File: doc/BRIEF.md
# Escalating Fault Recovery Sequencer

This block decides how a clock generator channel is brought back into service after a clock monitor flags it as faulty. While idle it waits for an error indication. When one arrives it runs the recovery recipe chosen by the operator: a reset pulse alone, a configuration scrub alone, or an escalating recipe. The escalating recipe tries a reset first, falls back to a scrub when the reset does not help, and then issues a second reset. Each reset is followed by a settling wait whose length is chosen per event, short for a channel driving its input clock straight through and long for a channel synthesising a new frequency. A scrub needs no settling wait, because it leaves the generator's lock undisturbed.

The generator's own lock indication is never consulted, since it does not reliably reveal an upset. Success is judged only by the monitor's independent healthy input. Each handled event is classed as a data-path fault (cured by reset), a configuration fault (cured only after a scrub) or unrecovered. Each class has its own saturating counter. An unrecovered event also raises a sticky fault flag. Errors reported while a recipe is in progress are dropped. The scrub engine sits outside the block and is driven through a request/done handshake.

Top module: `fault_recovery_seq`

## Requirements
- R1: While rst_n is low and after release, gen_rst_o, scrub_req_o, busy_o, evt_valid_o and fault_o are 0, evt_class_o is 0 and all three counters are 0.
- R2: The block leaves idle only when err_i is 1 at a clock edge while it is idle. Any err_i seen while busy_o is 1 has no effect on the outputs or counters. busy_o is 1 from the cycle after acceptance until the event is reported.
- R3: Each reset step drives gen_rst_o high for exactly RST_CYC consecutive cycles (RST_CYC at least 3). The first reset step starts in the cycle after the error is accepted.
- R4: After each reset step the block waits SETTLE_FAST cycles if slow_i was 0 when the error was accepted, and SETTLE_SLOW cycles if it was 1. It judges healthy_i in the last cycle of that wait.
- R5: mode_i encoding: 0 = reset only, 1 = scrub only, 2 or 3 = escalating. In escalating mode, a healthy result after the first reset gives class 1 (data-path).
- R6: In escalating mode, an unhealthy result after the first reset raises scrub_req_o and holds it until scrub_done_i is 1. A second reset and settle follow. A healthy result at that point gives class 2 (configuration).
- R7: A failed final check gives class 3 (unrecovered) and sets fault_o, which stays 1 until rst_n.
- R8: In reset-only mode, one reset and settle is done. A healthy result gives class 1, otherwise class 3.
- R9: In scrub-only mode, scrub_req_o is raised in the cycle after acceptance and no reset is issued. The result is judged from healthy_i in the cycle scrub_done_i is seen: healthy gives class 2, otherwise class 3. scrub_done_i has no effect while scrub_req_o is 0.
- R10: A result is reported the cycle after it is judged. evt_valid_o pulses for one cycle, evt_class_o carries the class and holds it afterwards, busy_o drops, and the matching counter increments in that same cycle. Counters stay at all-ones once reached.
- R11: gen_rst_o and scrub_req_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Error reported by the clock monitor |
| healthy_i | input | 1 | Monitor's independent check that the channel runs correctly |
| mode_i | input | 2 | Recovery recipe: 0 reset, 1 scrub, 2/3 escalating |
| slow_i | input | 1 | Selects the long settling wait |
| scrub_done_i | input | 1 | Scrub engine finished |
| gen_rst_o | output | 1 | Reset to the clock generator |
| scrub_req_o | output | 1 | Scrub request, held until done |
| busy_o | output | 1 | A recovery recipe is running |
| evt_valid_o | output | 1 | One-cycle result pulse |
| evt_class_o | output | 2 | Result class: 1 data-path, 2 configuration, 3 unrecovered |
| fault_o | output | 1 | Sticky unrecovered flag |
| cnt_dp_o | output | CNT_W | Data-path event count |
| cnt_cfg_o | output | CNT_W | Configuration event count |
| cnt_unrec_o | output | CNT_W | Unrecovered event count |

## Verification
An accepted error shows as busy_o and the first reset (or scrub request) one cycle later. A reset step plus settle lasts RST_CYC plus the selected settle length. The verdict, counter increment and sticky flag all appear one cycle after the healthy sample or scrub completion that decides them. A behavioural reference in the bench advances on the same edge with the same inputs, and every output is compared half a cycle after each edge, so each result is checked in exactly the cycle it is due. Per-event checks then confirm the class against the mode table and count the reset-high cycles.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RST    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_SCRUB  = 2'd3
    } fr_state_e;

    typedef enum logic [1:0] {
        MD_RST   = 2'd0,
        MD_SCRUB = 2'd1,
        MD_ESC   = 2'd2
    } fr_mode_e;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_DP    = 2'd1,
        CL_CFG   = 2'd2,
        CL_UNREC = 2'd3
    } fr_class_e;

    localparam int NUM_CLASSES = 3;

    typedef struct packed {
        fr_state_e st;
        logic      second;
        fr_mode_e  mode;
        logic      slow;
        logic      evt;
        fr_class_e cls;
        logic      fault;
    } fr_ctl_t;

    function automatic fr_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'd0:    return MD_RST;
            2'd1:    return MD_SCRUB;
            default: return MD_ESC;
        endcase
    endfunction

endpackage

// File: rtl/fr_cycle_timer.sv
module fr_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == limit - ONE);

    // the count restarts from zero after every clear
    a_r3_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/fr_sat_counter.sv
module fr_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != MAXV) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == MAXV |=> cnt_q == MAXV);
    a_r10_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));

endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
    import fr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RST_CYC     = 8,
    parameter int SETTLE_FAST = 24000,
    parameter int SETTLE_SLOW = 2000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             healthy_i,
    input  logic [1:0]       mode_i,
    input  logic             slow_i,
    input  logic             scrub_done_i,
    output logic             gen_rst_o,
    output logic             scrub_req_o,
    output logic             busy_o,
    output logic             evt_valid_o,
    output logic [1:0]       evt_class_o,
    output logic             fault_o,
    output logic [CNT_W-1:0] cnt_dp_o,
    output logic [CNT_W-1:0] cnt_cfg_o,
    output logic [CNT_W-1:0] cnt_unrec_o
);
    localparam int MAX_LIM = (SETTLE_SLOW > SETTLE_FAST) ?
                             ((SETTLE_SLOW > RST_CYC) ? SETTLE_SLOW : RST_CYC) :
                             ((SETTLE_FAST > RST_CYC) ? SETTLE_FAST : RST_CYC);
    localparam int TW = $clog2(MAX_LIM + 1);
    localparam logic [TW-1:0] LIM_RST  = TW'(RST_CYC);
    localparam logic [TW-1:0] LIM_FAST = TW'(SETTLE_FAST);
    localparam logic [TW-1:0] LIM_SLOW = TW'(SETTLE_SLOW);

    fr_ctl_t ctl_d, ctl_q;
    logic          tmr_clr, tmr_done;
    logic [TW-1:0] tmr_limit;
    logic [NUM_CLASSES-1:0]  cls_inc;
    logic [CNT_W-1:0]        cls_cnt [NUM_CLASSES];

    // ---------------- next-state logic ----------------
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.evt = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (err_i) begin
                    ctl_d.mode   = decode_mode(mode_i);
                    ctl_d.slow   = slow_i;
                    ctl_d.second = 1'b0;
                    ctl_d.st     = (decode_mode(mode_i) == MD_SCRUB) ? ST_SCRUB : ST_RST;
                end
            end
            ST_RST: begin
                if (tmr_done) ctl_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    if (healthy_i) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.evt = 1'b1;
                        ctl_d.cls = ctl_q.second ? CL_CFG : CL_DP;
                    end else if (ctl_q.mode == MD_ESC && !ctl_q.second) begin
                        ctl_d.st = ST_SCRUB;
                    end else begin
                        ctl_d.st    = ST_IDLE;
                        ctl_d.evt   = 1'b1;
                        ctl_d.cls   = CL_UNREC;
                        ctl_d.fault = 1'b1;
                    end
                end
            end
            ST_SCRUB: begin
                if (scrub_done_i) begin
                    if (ctl_q.mode == MD_SCRUB) begin
                        ctl_d.st    = ST_IDLE;
                        ctl_d.evt   = 1'b1;
                        ctl_d.cls   = healthy_i ? CL_CFG : CL_UNREC;
                        ctl_d.fault = ctl_q.fault | !healthy_i;
                    end else begin
                        ctl_d.second = 1'b1;
                        ctl_d.st     = ST_RST;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, second: 1'b0, mode: MD_RST, slow: 1'b0,
                       evt: 1'b0, cls: CL_NONE, fault: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // ---------------- step timer ----------------
    always_comb begin
        tmr_clr   = (ctl_d.st != ctl_q.st);
        tmr_limit = (ctl_q.st == ST_RST) ? LIM_RST : (ctl_q.slow ? LIM_SLOW : LIM_FAST);
    end

    fr_cycle_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    // ---------------- per-class counters ----------------
    for (genvar gi = 0; gi < NUM_CLASSES; gi++) begin : g_cls
        assign cls_inc[gi] = ctl_d.evt && (ctl_d.cls == fr_class_e'(gi + 1));
        fr_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cls_inc[gi]),
            .cnt_o (cls_cnt[gi])
        );
    end

    // ---------------- outputs ----------------
    assign gen_rst_o   = (ctl_q.st == ST_RST);
    assign scrub_req_o = (ctl_q.st == ST_SCRUB);
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign evt_valid_o = ctl_q.evt;
    assign evt_class_o = ctl_q.cls;
    assign fault_o     = ctl_q.fault;
    assign cnt_dp_o    = cls_cnt[0];
    assign cnt_cfg_o   = cls_cnt[1];
    assign cnt_unrec_o = cls_cnt[2];

    // ---------------- assertions ----------------
    a_r11_rst_scrub_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_rst_o && scrub_req_o));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |=> !evt_valid_o);
    a_r10_class_valid: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (evt_class_o != 2'd0 && !busy_o));
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);
    a_r3_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_rst_o) |=> gen_rst_o);
    a_r2_busy_ignores_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !evt_valid_o && $past(busy_o)) |-> $stable(fault_o) || evt_valid_o);
    a_r9_scrub_held: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req_o && !scrub_done_i) |=> scrub_req_o);

endmodule

// File: tb/tb_fault_recovery_seq.sv
module tb_fault_recovery_seq;
    localparam int CNT_W = 2;
    localparam int RST_CYC = 3;
    localparam int SETTLE_FAST = 5;
    localparam int SETTLE_SLOW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_i = 1'b0, healthy_i = 1'b0, slow_i = 1'b0, scrub_done_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic gen_rst_o, scrub_req_o, busy_o, evt_valid_o, fault_o;
    logic [1:0] evt_class_o;
    logic [CNT_W-1:0] cnt_dp_o, cnt_cfg_o, cnt_unrec_o;

    always #2.5 clk = ~clk;

    fault_recovery_seq #(.CNT_W(CNT_W), .RST_CYC(RST_CYC),
                         .SETTLE_FAST(SETTLE_FAST), .SETTLE_SLOW(SETTLE_SLOW)) dut (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .healthy_i(healthy_i),
        .mode_i(mode_i), .slow_i(slow_i), .scrub_done_i(scrub_done_i),
        .gen_rst_o(gen_rst_o), .scrub_req_o(scrub_req_o), .busy_o(busy_o),
        .evt_valid_o(evt_valid_o), .evt_class_o(evt_class_o), .fault_o(fault_o),
        .cnt_dp_o(cnt_dp_o), .cnt_cfg_o(cnt_cfg_o), .cnt_unrec_o(cnt_unrec_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 reset pulse, 2 settling, 3 scrubbing
    int m_phase = 0, m_rem = 0, m_mode = 0, m_cls = 0;
    bit m_slow = 0, m_second = 0, m_evt = 0, m_fault = 0;
    int m_cnt [3] = '{0, 0, 0};
    int maxc = (1 << CNT_W) - 1;

    function automatic void m_finish(input int c);
        m_phase = 0; m_evt = 1; m_cls = c;
        if (m_cnt[c-1] < maxc) m_cnt[c-1]++;
        if (c == 3) m_fault = 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rem = 0; m_mode = 0; m_cls = 0; m_slow = 0;
            m_second = 0; m_evt = 0; m_fault = 0; m_cnt = '{0, 0, 0};
        end else begin
            m_evt = 0;
            case (m_phase)
                0: if (err_i) begin
                    m_mode = (mode_i >= 2) ? 2 : int'(mode_i);
                    m_slow = slow_i; m_second = 0;
                    if (m_mode == 1) m_phase = 3;
                    else begin m_phase = 1; m_rem = RST_CYC; end
                end
                1: begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_phase = 2; m_rem = m_slow ? SETTLE_SLOW : SETTLE_FAST;
                    end
                end
                2: begin
                    m_rem--;
                    if (m_rem == 0) begin
                        if (healthy_i) m_finish(m_second ? 2 : 1);
                        else if (m_mode == 2 && !m_second) m_phase = 3;
                        else m_finish(3);
                    end
                end
                default: if (scrub_done_i) begin
                    if (m_mode == 1) m_finish(healthy_i ? 2 : 3);
                    else begin m_second = 1; m_phase = 1; m_rem = RST_CYC; end
                end
            endcase
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    bit compare_on = 0;
    int last_cls = 0;
    int rst_hi = 0;

    always @(negedge clk) begin
        if (compare_on) begin
            chk(gen_rst_o == (m_phase == 1), "R3 gen_rst_o", gen_rst_o, m_phase == 1);
            chk(scrub_req_o == (m_phase == 3), "R6 scrub_req_o", scrub_req_o, m_phase == 3);
            chk(busy_o == (m_phase != 0), "R4 busy_o", busy_o, m_phase != 0);
            chk(evt_valid_o == m_evt, "R10 evt_valid_o", evt_valid_o, m_evt);
            chk(int'(evt_class_o) == m_cls, "R10 evt_class_o", evt_class_o, m_cls);
            chk(fault_o == m_fault, "R7 fault_o", fault_o, m_fault);
            chk(int'(cnt_dp_o) == m_cnt[0], "R10 cnt_dp_o", cnt_dp_o, m_cnt[0]);
            chk(int'(cnt_cfg_o) == m_cnt[1], "R10 cnt_cfg_o", cnt_cfg_o, m_cnt[1]);
            chk(int'(cnt_unrec_o) == m_cnt[2], "R10 cnt_unrec_o", cnt_unrec_o, m_cnt[2]);
            chk(!(gen_rst_o && scrub_req_o), "R11 exclusive", gen_rst_o, 0);
        end
        if (evt_valid_o) last_cls = evt_class_o;
        if (gen_rst_o) rst_hi++;
    end

    // ---------------- one recovery event ----------------
    task automatic run_case(input int md, input bit sl, input bit h1, input bit h2,
                            input int exp_cls, input int exp_resets, input bit noise,
                            input string tag);
        int scr = 0;
        @(negedge clk);
        mode_i = 2'(md); slow_i = sl; healthy_i = h1; err_i = 1'b1;
        last_cls = 0; rst_hi = 0;
        @(negedge clk);
        err_i = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            scrub_done_i = 1'b0;
            if (!busy_o) break;
            err_i = noise && (k % 3 == 0);   // R2: must be ignored
            if (noise) mode_i = 2'd1;
            if (scrub_req_o) begin
                scr++;
                if (scr == 3) begin scrub_done_i = 1'b1; healthy_i = h2; scr = 0; end
            end
        end
        err_i = 1'b0; scrub_done_i = 1'b0;
        @(negedge clk);
        chk(last_cls == exp_cls, tag, last_cls, exp_cls);
        chk(rst_hi == exp_resets * RST_CYC, "R3 reset cycles", rst_hi, exp_resets * RST_CYC);
    endtask

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        compare_on = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !gen_rst_o && !scrub_req_o && !fault_o, "R1 reset outputs", busy_o, 0);
        chk(cnt_dp_o == 0 && cnt_cfg_o == 0 && cnt_unrec_o == 0, "R1 counters", cnt_dp_o, 0);
        rst_n = 1'b1;
        // R9: scrub done while idle has no effect
        @(negedge clk); scrub_done_i = 1'b1;
        @(negedge clk); scrub_done_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !scrub_req_o, "R9 stray done ignored", busy_o, 0);

        run_case(2, 0, 1, 1, 1, 1, 0, "R5 escalate data-path");
        run_case(2, 1, 0, 1, 2, 2, 0, "R6 escalate config (slow settle R4)");
        run_case(2, 0, 0, 0, 3, 2, 0, "R7 escalate unrecovered");
        chk(fault_o == 1, "R7 fault set", fault_o, 1);
        run_case(0, 0, 1, 1, 1, 1, 0, "R8 reset-only healthy");
        run_case(0, 1, 0, 1, 3, 1, 0, "R8 reset-only failed");
        run_case(1, 0, 0, 1, 2, 0, 0, "R9 scrub-only healthy");
        run_case(1, 1, 1, 0, 3, 0, 0, "R9 scrub-only failed");
        run_case(3, 0, 0, 1, 2, 2, 0, "R5 mode 3 escalates");
        run_case(2, 0, 1, 1, 1, 1, 1, "R2 errors while busy ignored");
        run_case(2, 1, 1, 1, 1, 1, 1, "R2 errors while busy ignored slow");
        chk(cnt_dp_o == 2'd3, "R10 saturation", cnt_dp_o, 3);
        chk(fault_o == 1, "R7 fault sticky", fault_o, 1);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule